// File: doc/BRIEF.md
# Extended Shifter with Rotation Capture Register

This block is a 32-bit shift engine with its own 32-bit capture register, called MQ here. Every accepted operation rotates the source word left by the shift count and stores that rotation in MQ. Each operation also produces a shift result. The merge operations splice the new rotation with the old MQ contents under a generated mask, so that a long value can be shifted one word at a time across consecutive operations. The arithmetic right shift also reports whether a negative source lost any 1 bits.

The shift count comes from either a 5-bit immediate or a 6-bit register amount. For a register amount, bit 5 marks a count of 32 or more. The plain shifts and the range-checked merge forms respond to that bit. The result, MQ and the carry flag are all registered, and the result appears one clock after the operation is accepted.

Top module: `shu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, `res_o`, `mq_o`, `carry_o` and `res_valid_o` all become zero at that edge.
- R2: Every legal accepted operation (`op_valid` high and `op_code` not 7) loads MQ with the source rotated left by n. When n is 0, MQ receives the source unchanged.
- R3: For `op_code` 0 the result is the source shifted left logically by n. For `op_code` 1 the result is the source shifted right logically by n. Both give zero when the register amount has bit 5 set.
- R4: For `op_code` 2, the mask has ones at bit positions n and above (bit 0 is the least significant bit). The result is (rotation AND mask) OR (old MQ AND NOT mask).
- R5: For `op_code` 3, the mask has ones at bit positions 31−n and below. The result is the same splice of the rotation with the old MQ.
- R6: `op_code` 4 and `op_code` 5 behave as 2 and 3 when bit 5 of the register amount is clear. When that bit is set, the result is old MQ AND the mask of that form.
- R7: For `op_code` 6, the result is the source shifted right arithmetically by n, with bit 31 copied into the vacated bits. The carry is set only when bit 31 of the source is 1 and at least one of its n lowest bits is 1. Otherwise the carry is cleared. Bit 5 of the amount is ignored for this form.
- R8: Legal operations other than `op_code` 6 leave the carry unchanged.
- R9: An idle cycle, or an accepted `op_code` 7, leaves MQ, the result and the carry unchanged and drives `res_valid_o` low.
- R10: When `use_imm` is high, n is `imm_amt`, `reg_amt` is ignored, and the out-of-range case never applies.
- R11: `res_valid_o` is high exactly one cycle after a legal operation is accepted. The result, MQ and the carry change at that same edge.

Here n is `imm_amt` when `use_imm` is high, and `reg_amt[4:0]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 3 | Operation select, 0..6 as listed in the requirements, 7 reserved |
| use_imm | input | 1 | Take the count from `imm_amt` |
| imm_amt | input | 5 | Immediate shift count |
| reg_amt | input | 6 | Register shift count, bit 5 marks 32 or more |
| src | input | 32 | Source word |
| res_o | output | 32 | Registered shift result |
| mq_o | output | 32 | MQ capture register |
| carry_o | output | 1 | Carry flag from the arithmetic right shift |
| res_valid_o | output | 1 | Result updated this cycle |

## Verification
The bench targets a count of zero, where a rotator that shifts by the full width would load MQ with zero instead of the source. It also targets register counts of 32 and above. A design that ignored bit 5 there would return a shifted word instead of zero or the masked old MQ. The arithmetic shift is driven with negative sources whose discarded bits are all zero, and with positive sources that have ones in those bits. A carry built from the sign alone, or from the lost bits alone, gets one of these wrong. Back-to-back merges check that the splice uses the MQ from the previous operation and not the rotation being written in the same cycle.

// File: rtl/shu_pkg.sv
// Package: shared operation codes for the extended shift unit.
// Assumes a 3-bit operation field; code 7 is reserved and performs nothing.
package shu_pkg;
    typedef enum logic [2:0] {
        OP_SHL     = 3'd0,
        OP_SHR     = 3'd1,
        OP_MGL     = 3'd2,
        OP_MGR     = 3'd3,
        OP_MGL_RC  = 3'd4,
        OP_MGR_RC  = 3'd5,
        OP_SRA     = 3'd6,
        OP_NONE    = 3'd7
    } shu_op_e;
endpackage

// File: rtl/shu_rotl.sv
// Module: logarithmic left rotator.
// Rotates din left by amt with one mux stage per bit of amt. A count of
// zero passes din through, so no shift by the full width ever occurs.
// Assumes W is a power of two.
module shu_rotl #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        // stage k: rotate by 2**k when that count bit is set
        assign stg[k+1] = amt[k] ? {stg[k][W-1-D:0], stg[k][W-1:W-D]} : stg[k];
    end

    assign dout = stg[SW];
endmodule

// File: rtl/shu_mask_gen.sv
// Module: merge mask generator.
// lmask has ones at bit positions >= n (the kept part of a left shift).
// rmask has ones at bit positions <= W-1-n (the kept part of a right shift).
// Each bit is a constant compare against n, with no shifter.
module shu_mask_gen #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [SW-1:0] n,
    output logic [W-1:0]  lmask,
    output logic [W-1:0]  rmask
);
    logic [SW:0] n_x;
    assign n_x = {1'b0, n};

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [SW:0] POS  = (SW+1)'(i);
        localparam logic [SW:0] ROOM = (SW+1)'(W - 1 - i);
        // bit i: compare its position with the shift count
        assign lmask[i] = (POS >= n_x);
        assign rmask[i] = (n_x <= ROOM);
    end
endmodule

// File: rtl/shu_rshift.sv
// Module: right shifter with the shifted-out-bit carry.
// Produces the logical and the arithmetic right shift of src by n.
// carry is set only for a negative src that loses a 1 bit. lmask from the
// mask generator marks the bits that survive, so NOT lmask marks the lost bits.
module shu_rshift #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [SW-1:0] n,
    input  logic [W-1:0]  lmask,
    output logic [W-1:0]  srl,
    output logic [W-1:0]  sra,
    output logic          carry
);
    // logical and sign-filling right shift
    always_comb begin
        srl = src >> n;
        sra = W'($signed(src) >>> n);
    end

    // carry: negative source with at least one 1 bit discarded
    assign carry = src[W-1] & (|(src & ~lmask));
endmodule

// File: rtl/shu_core.sv
// Module: extended shift unit with the MQ capture register (top).
// One legal operation per cycle; the result, MQ and the carry register at
// the next rising edge. MQ always takes the left rotation of src by n.
// Merge forms splice with the MQ value held before the operation.
// Reset is synchronous and active low. Assumes W is a power of two.
module shu_core #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic          use_imm,
    input  logic [SW-1:0] imm_amt,
    input  logic [SW:0]   reg_amt,
    input  logic [W-1:0]  src,
    output logic [W-1:0]  res_o,
    output logic [W-1:0]  mq_o,
    output logic          carry_o,
    output logic          res_valid_o
);
    import shu_pkg::*;

    shu_op_e       op;
    logic [SW-1:0] n_eff;
    logic          big;
    logic          legal;
    logic [W-1:0]  rot, lmask, rmask, srl, sra;
    logic          sra_carry;
    logic [W-1:0]  merge_l, merge_r;
    logic [W-1:0]  res_next;
    logic          carry_next;

    assign op = shu_op_e'(op_code);

    // count select: the immediate never reaches the out-of-range case
    always_comb begin
        n_eff = use_imm ? imm_amt : reg_amt[SW-1:0];
        big   = ~use_imm & reg_amt[SW];
    end

    assign legal = op_valid && (op != OP_NONE);

    shu_rotl #(.W(W)) rot_i (
        .din  (src),
        .amt  (n_eff),
        .dout (rot)
    );

    shu_mask_gen #(.W(W)) mask_i (
        .n     (n_eff),
        .lmask (lmask),
        .rmask (rmask)
    );

    shu_rshift #(.W(W)) rsh_i (
        .src   (src),
        .n     (n_eff),
        .lmask (lmask),
        .srl   (srl),
        .sra   (sra),
        .carry (sra_carry)
    );

    // splice the rotation with the previous MQ under each mask
    always_comb begin
        merge_l = (rot & lmask) | (mq_o & ~lmask);
        merge_r = (rot & rmask) | (mq_o & ~rmask);
    end

    // result and carry select by operation
    always_comb begin
        res_next   = res_o;
        carry_next = carry_o;
        unique case (op)
            OP_SHL:    res_next = big ? '0 : (rot & lmask);
            OP_SHR:    res_next = big ? '0 : srl;
            OP_MGL:    res_next = merge_l;
            OP_MGR:    res_next = merge_r;
            OP_MGL_RC: res_next = big ? (mq_o & lmask) : merge_l;
            OP_MGR_RC: res_next = big ? (mq_o & rmask) : merge_r;
            OP_SRA: begin
                res_next   = sra;
                carry_next = sra_carry;
            end
            OP_NONE:   res_next = res_o;
        endcase
    end

    // output, MQ and carry registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o       <= '0;
            mq_o        <= '0;
            carry_o     <= 1'b0;
            res_valid_o <= 1'b0;
        end else begin
            res_valid_o <= legal;
            if (legal) begin
                res_o   <= res_next;
                mq_o    <= rot;
                carry_o <= carry_next;
            end
        end
    end

    // R1: reset clears MQ at the next edge
    p_mq_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mq_o == '0 && !res_valid_o && !carry_o));

    // R2: MQ holds the left rotation of the accepted source
    p_mq_rotation_r2: assert property (@(posedge clk) disable iff (!rst_n)
        legal |=> (mq_o == (($past(src) << $past(n_eff)) | ($past(src) >> (W - $past(n_eff))))));

    // R9: without a legal operation MQ and the result do not move
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |=> ($stable(mq_o) && $stable(res_o) && !res_valid_o));

    // R8: only the arithmetic shift touches the carry
    p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && op != OP_SRA) |=> $stable(carry_o));

    // R7: a set carry always comes from a negative source
    p_carry_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && op == OP_SRA) |=> (carry_o |-> $past(src[W-1])));

    // R3: out-of-range plain shifts give zero
    p_big_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && big && (op == OP_SHL || op == OP_SHR)) |=> (res_o == '0));

    // R11: one-cycle result latency
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        legal |=> res_valid_o);
endmodule

// File: tb/shu_core_tb.sv
`timescale 1ns/1ps
module shu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        use_imm = 1'b0;
    logic [4:0]  imm_amt = 5'd0;
    logic [5:0]  reg_amt = 6'd0;
    logic [31:0] src = 32'd0;
    logic [31:0] res_o, mq_o;
    logic        carry_o, res_valid_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_res = 0, m_mq = 0;
    logic        m_carry = 0;

    always #10 clk = ~clk;

    shu_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .use_imm(use_imm), .imm_amt(imm_amt), .reg_amt(reg_amt), .src(src),
        .res_o(res_o), .mq_o(mq_o), .carry_o(carry_o), .res_valid_o(res_valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rotl_m(input logic [31:0] s, input int n);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[(i + n) % 32] = s[i];
        return r;
    endfunction

    function automatic logic [31:0] lmask_m(input int n);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (i >= n);
        return m;
    endfunction

    function automatic logic [31:0] rmask_m(input int n);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (i <= 31 - n);
        return m;
    endfunction

    // drive one cycle, advance the model, check after the edge
    task automatic step(input bit v, input int op, input logic [31:0] s, input bit ui,
                        input int imm, input int ramt, input string tag);
        int n; bit big; logic [31:0] rot, lm, rm, r; bit legal;
        op_valid = v; op_code = op[2:0]; src = s; use_imm = ui;
        imm_amt = imm[4:0]; reg_amt = ramt[5:0];
        n   = ui ? imm : (ramt % 32);
        big = !ui && (ramt >= 32);
        rot = rotl_m(s, n); lm = lmask_m(n); rm = rmask_m(n);
        legal = v && (op != 7);
        if (legal) begin
            case (op)
                0: begin r = 0; for (int i = 0; i < 32; i++) if (i >= n) r[i] = s[i-n]; if (big) r = 0; end
                1: begin r = 0; for (int i = 0; i < 32; i++) if (i + n <= 31) r[i] = s[i+n]; if (big) r = 0; end
                2: r = (rot & lm) | (m_mq & ~lm);
                3: r = (rot & rm) | (m_mq & ~rm);
                4: r = big ? (m_mq & lm) : ((rot & lm) | (m_mq & ~lm));
                5: r = big ? (m_mq & rm) : ((rot & rm) | (m_mq & ~rm));
                default: begin
                    bit lost = 0;
                    for (int i = 0; i < 32; i++) r[i] = (i + n <= 31) ? s[i+n] : s[31];
                    for (int i = 0; i < n; i++) if (s[i]) lost = 1;
                    m_carry = s[31] && lost;
                end
            endcase
            m_res = r;
            m_mq  = rot;
        end
        @(posedge clk);
        #5;
        chk(tag, res_o, m_res, "result");
        chk(legal ? "R2" : "R9", mq_o, m_mq, "mq");
        chk(op == 6 ? "R7" : "R8", {31'd0, carry_o}, {31'd0, m_carry}, "carry");
        chk("R11", {31'd0, res_valid_o}, {31'd0, legal}, "valid");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        op_valid = 1'b1; op_code = 3'd2; src = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", res_o, 0, "result"); chk("R1", mq_o, 0, "mq");
        chk("R1", {31'd0, carry_o}, 0, "carry"); chk("R1", {31'd0, res_valid_o}, 0, "valid");
        rst_n = 1'b1; op_valid = 1'b0;
        step(0, 0, 32'h0, 0, 0, 0, "R9");
        // R2: zero count keeps the source in MQ
        step(1, 0, 32'hDEAD_BEEF, 1, 0, 0, "R2");
        step(1, 1, 32'h8000_0001, 0, 0, 0, "R2");
        // R3 plain shifts and out-of-range
        step(1, 0, 32'h8000_0001, 1, 4, 0, "R3");
        step(1, 1, 32'hF000_000F, 0, 0, 7, "R3");
        step(1, 0, 32'h1234_5678, 0, 0, 32, "R3");
        step(1, 1, 32'h1234_5678, 0, 0, 63, "R3");
        // R4 / R5 merges chained on the previous MQ
        step(1, 2, 32'hA5A5_0F0F, 0, 0, 8, "R4");
        step(1, 2, 32'h0102_0304, 1, 31, 0, "R4");
        step(1, 3, 32'hCAFE_F00D, 0, 0, 12, "R5");
        step(1, 3, 32'h7777_1111, 1, 1, 0, "R5");
        // R6 range-checked merges, both halves
        step(1, 4, 32'h1357_9BDF, 0, 0, 40, "R6");
        step(1, 4, 32'h2468_ACE0, 0, 0, 5, "R6");
        step(1, 5, 32'hFEDC_BA98, 0, 0, 35, "R6");
        step(1, 5, 32'h0F1E_2D3C, 0, 0, 3, "R6");
        // R7 carry cases
        step(1, 6, 32'h8000_0010, 1, 4, 0, "R7");
        step(1, 6, 32'h8000_0010, 1, 5, 0, "R7");
        step(1, 6, 32'h7000_00FF, 1, 8, 0, "R7");
        step(1, 6, 32'hFFFF_FFFF, 0, 0, 33, "R7");
        // R8 carry kept through other forms
        step(1, 0, 32'h1, 1, 1, 0, "R8");
        // R9 reserved code and idle
        step(1, 7, 32'hFFFF_0000, 0, 0, 9, "R9");
        step(0, 2, 32'hFFFF_0000, 0, 0, 9, "R9");
        // R10 immediate ignores register bit 5
        step(1, 0, 32'h0000_00FF, 1, 3, 63, "R10");
        step(1, 4, 32'h0000_00FF, 1, 2, 40, "R10");
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 7);
            step($urandom_range(0, 4) != 0, op, $urandom, $urandom_range(0, 1),
                 $urandom_range(0, 31), $urandom_range(0, 63), "R2");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule